// File: doc/BRIEF.md
# Keyboard Controller Host Command Sequencer

This block is the host-side register front end of a PS/2-style keyboard and mouse controller. The host sees two byte-wide ports, picked by a single address bit. Address 1 is the command port. Address 0 is the data port. Each command byte is decoded in the cycle it is written. Some commands take effect at once: they change a mode bit, set the self-test flag, queue a reply byte or request a system reset. Other commands arm a pending target, and the next data-port write goes to that target instead of to the keyboard device.

The pending targets are:
- the mode register;
- the output port;
- the keyboard side of the output buffer;
- the mouse side of the output buffer;
- the mouse device.

Reply bytes and device bytes leave the block as one-cycle strobes with a byte attached. The serial line protocol, the device models and the output buffer sit outside the block. The block reads the buffer's occupancy through `bufFull`, `bufAux` and `bufData`, and from these it forms the status register and the two interrupt requests.

Top module: `kbcSequencer`

## Requirements
- R1: After reset, the block is in this state. The mode register is 0x03. With `bufFull` low, a status read returns 0x18. `outPort` is 0xCF, `transEn` is 0, and all strobes are low.
- R2: Command 0x20 pulses `replyValid` with `replyAux`=0 and `replyByte` equal to the current mode byte.
- R3: Each of the commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arms one pending target. The next data write goes to that target:
  - 0x60 loads the mode register;
  - 0xD1 loads `outPort`;
  - 0xD2 sends a reply with `replyAux`=0;
  - 0xD3 sends a reply with `replyAux`=1;
  - 0xD4 sends a device write with `devWrMouse`=1.
  After that one data write, the pending target is cleared.
- R4: A data write with nothing pending pulses `devWrValid` with `devWrMouse`=0 and `devWrByte` equal to the written byte.
- R5: The fixed-reply commands behave as follows:
  - 0xAA sets status bit 2 and replies 0x55;
  - 0xA9 replies 0x00;
  - 0xAB replies 0x00;
  - 0xC0 replies 0x80.
- R6: Four commands change the disable bits of the mode register:
  - 0xA7 sets mode bit 5;
  - 0xA8 clears mode bit 5;
  - 0xAD sets mode bit 4;
  - 0xAE clears mode bit 4.

  The interrupt outputs are formed as follows:
  - `irqKbd` = `bufFull` & !`bufAux` & mode bit 0 & !mode bit 4;
  - `irqMouse` = `bufFull` & `bufAux` & mode bit 1.
- R7: `transEn` always equals mode bit 6.
- R8: Any command with upper nibble 0xF is a pulse command. If bit 0 of the command is 0, `sysResetReq` pulses for one cycle. If bit 0 is 1, the command has no effect apart from setting status bit 3.
- R9: Any other command code pulses `cmdErr` for one cycle and leaves the pending target, the mode register, the status bits and `outPort` unchanged.
- R10: The status byte is built from these bits:
  - bit 0 = `bufFull`;
  - bit 1 = 0;
  - bit 2 = self-test passed;
  - bit 3 = the last accepted write was a command (a data write clears it);
  - bit 4 = 1;
  - bit 5 = `bufFull` & `bufAux`;
  - bits 7:6 = 0.
- R11: `busRdata` is combinational. It shows the status byte when `busAddr` is 1 and `bufData` when `busAddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | One-cycle write strobe |
| busAddr | input | 1 | 1 = command/status port, 0 = data port |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte of the selected port |
| bufFull | input | 1 | Output buffer holds a byte |
| bufAux | input | 1 | Head byte of the buffer came from the mouse side |
| bufData | input | 8 | Head byte of the output buffer |
| replyValid | output | 1 | Reply byte strobe toward the output buffer |
| replyAux | output | 1 | Reply is tagged as mouse-side |
| replyByte | output | 8 | Reply byte |
| devWrValid | output | 1 | Byte strobe toward a device |
| devWrMouse | output | 1 | 1 = mouse device, 0 = keyboard device |
| devWrByte | output | 8 | Device byte |
| outPort | output | 8 | Output port register |
| transEn | output | 1 | Scan-code translation enable |
| irqKbd | output | 1 | Keyboard interrupt request |
| irqMouse | output | 1 | Mouse interrupt request |
| sysResetReq | output | 1 | One-cycle system reset request |
| cmdErr | output | 1 | One-cycle unsupported-command strobe |

## Verification
Every strobe (`replyValid`, `devWrValid`, `sysResetReq`, `cmdErr`) is registered. Each one is high for exactly the one cycle that follows the edge at which the write was taken. The mode, `outPort` and status state change at that same edge, so `transEn`, the interrupts and a status read reflect a write from that cycle onward. The bench drives each write strobe between falling edges. It samples strobes and state at the falling edge that follows the accepting rising edge. It samples the combinational read path one time step after changing `busAddr`.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BW = 8;

  typedef enum logic [2:0] {
    PEND_NONE, PEND_MODE, PEND_OUTP, PEND_KBUF, PEND_MBUF, PEND_MDEV
  } pend_e;

  typedef enum logic [1:0] {SRC_CONST, SRC_MODE, SRC_WDATA} rsrc_e;

  typedef struct packed {
    logic          cmdWrite;
    logic          dataWrite;
    logic          ldMode;
    logic          ldOutPort;
    logic          setMouseDis;
    logic          clrMouseDis;
    logic          setKbdDis;
    logic          clrKbdDis;
    logic          setSelfTest;
    logic          queueReply;
    logic          replyAux;
    rsrc_e         replySrc;
    logic [BW-1:0] constByte;
    logic          devWr;
    logic          devMouse;
    logic          sysReset;
    logic          cmdErr;
  } ctl_t;

  localparam int MODE_KINT_BIT  = 0;
  localparam int MODE_MINT_BIT  = 1;
  localparam int MODE_KDIS_BIT  = 4;
  localparam int MODE_MDIS_BIT  = 5;
  localparam int MODE_TRANS_BIT = 6;
endpackage

// File: rtl/kbcCtrl.sv
module kbcCtrl
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWr,
  input  logic          busAddr,
  input  logic [BW-1:0] busWdata,
  output ctl_t          ctl
);
  pend_e pendQ, pendD;
  logic  cmdStb, dataStb;

  assign cmdStb  = busWr & busAddr;
  assign dataStb = busWr & ~busAddr;

  always_comb begin
    ctl   = '0;
    pendD = pendQ;
    if (cmdStb) begin
      ctl.cmdWrite = 1'b1;
      if (busWdata[7:4] == 4'hF) begin
        ctl.sysReset = ~busWdata[0];
      end else begin
        unique case (busWdata)
          8'h20: begin ctl.queueReply = 1'b1; ctl.replySrc = SRC_MODE; end
          8'h60: pendD = PEND_MODE;
          8'hD1: pendD = PEND_OUTP;
          8'hD2: pendD = PEND_KBUF;
          8'hD3: pendD = PEND_MBUF;
          8'hD4: pendD = PEND_MDEV;
          8'hA7: ctl.setMouseDis = 1'b1;
          8'hA8: ctl.clrMouseDis = 1'b1;
          8'hA9: begin ctl.queueReply = 1'b1; ctl.constByte = 8'h00; end
          8'hAA: begin
            ctl.setSelfTest = 1'b1;
            ctl.queueReply  = 1'b1;
            ctl.constByte   = 8'h55;
          end
          8'hAB: begin ctl.queueReply = 1'b1; ctl.constByte = 8'h00; end
          8'hAD: ctl.setKbdDis = 1'b1;
          8'hAE: ctl.clrKbdDis = 1'b1;
          8'hC0: begin ctl.queueReply = 1'b1; ctl.constByte = 8'h80; end
          default: begin
            ctl.cmdWrite = 1'b0;
            ctl.cmdErr   = 1'b1;
          end
        endcase
      end
    end else if (dataStb) begin
      ctl.dataWrite = 1'b1;
      pendD         = PEND_NONE;
      unique case (pendQ)
        PEND_MODE: ctl.ldMode    = 1'b1;
        PEND_OUTP: ctl.ldOutPort = 1'b1;
        PEND_KBUF: begin ctl.queueReply = 1'b1; ctl.replySrc = SRC_WDATA; end
        PEND_MBUF: begin
          ctl.queueReply = 1'b1;
          ctl.replySrc   = SRC_WDATA;
          ctl.replyAux   = 1'b1;
        end
        PEND_MDEV: begin ctl.devWr = 1'b1; ctl.devMouse = 1'b1; end
        default:   ctl.devWr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= PEND_NONE;
    else       pendQ <= pendD;
  end

  // R3: one data write always consumes the pending target
  a_r3_pend_cleared: assert property (@(posedge clk) disable iff (!rstN)
    dataStb |=> pendQ == PEND_NONE);
  // R9: a rejected command keeps the pending target
  a_r9_err_keeps_pend: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmdErr |=> $stable(pendQ));
endmodule

// File: rtl/kbcDatapath.sv
module kbcDatapath
  import kbc_pkg::*;
#(
  parameter logic [BW-1:0] MODE_RST = 8'h03,
  parameter logic [BW-1:0] OUTP_RST = 8'hCF
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic [BW-1:0] busWdata,
  input  logic          busAddr,
  input  logic          bufFull,
  input  logic          bufAux,
  input  logic [BW-1:0] bufData,
  output logic [BW-1:0] busRdata,
  output logic          replyValid,
  output logic          replyAux,
  output logic [BW-1:0] replyByte,
  output logic          devWrValid,
  output logic          devWrMouse,
  output logic [BW-1:0] devWrByte,
  output logic [BW-1:0] outPort,
  output logic          transEn,
  output logic          irqKbd,
  output logic          irqMouse,
  output logic          sysResetReq,
  output logic          cmdErr
);
  logic [BW-1:0] modeQ, outPortQ, replyD, statusByte;
  logic          selfTestQ, lastCmdQ;

  always_comb begin
    unique case (ctl.replySrc)
      SRC_MODE:  replyD = modeQ;
      SRC_WDATA: replyD = busWdata;
      default:   replyD = ctl.constByte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_RST;
      outPortQ  <= OUTP_RST;
      selfTestQ <= 1'b0;
      lastCmdQ  <= 1'b1;
    end else begin
      if (ctl.ldMode) modeQ <= busWdata;
      else begin
        if (ctl.setMouseDis) modeQ[MODE_MDIS_BIT] <= 1'b1;
        if (ctl.clrMouseDis) modeQ[MODE_MDIS_BIT] <= 1'b0;
        if (ctl.setKbdDis)   modeQ[MODE_KDIS_BIT] <= 1'b1;
        if (ctl.clrKbdDis)   modeQ[MODE_KDIS_BIT] <= 1'b0;
      end
      if (ctl.ldOutPort)   outPortQ  <= busWdata;
      if (ctl.setSelfTest) selfTestQ <= 1'b1;
      if (ctl.cmdWrite)       lastCmdQ <= 1'b1;
      else if (ctl.dataWrite) lastCmdQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      replyValid  <= 1'b0;
      replyAux    <= 1'b0;
      replyByte   <= '0;
      devWrValid  <= 1'b0;
      devWrMouse  <= 1'b0;
      devWrByte   <= '0;
      sysResetReq <= 1'b0;
      cmdErr      <= 1'b0;
    end else begin
      replyValid  <= ctl.queueReply;
      devWrValid  <= ctl.devWr;
      sysResetReq <= ctl.sysReset;
      cmdErr      <= ctl.cmdErr;
      if (ctl.queueReply) begin
        replyAux  <= ctl.replyAux;
        replyByte <= replyD;
      end
      if (ctl.devWr) begin
        devWrMouse <= ctl.devMouse;
        devWrByte  <= busWdata;
      end
    end
  end

  assign statusByte = {2'b00, bufFull & bufAux, 1'b1, lastCmdQ, selfTestQ,
                       1'b0, bufFull};
  assign busRdata = busAddr ? statusByte : bufData;
  assign outPort  = outPortQ;
  assign transEn  = modeQ[MODE_TRANS_BIT];
  assign irqKbd   = bufFull & ~bufAux & modeQ[MODE_KINT_BIT] & ~modeQ[MODE_KDIS_BIT];
  assign irqMouse = bufFull & bufAux & modeQ[MODE_MINT_BIT];

  // R9: a rejected command touches no register
  a_r9_err_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmdErr |=> $stable(modeQ) && $stable(outPortQ) && $stable(lastCmdQ) && cmdErr);
  // R6: at most one interrupt line at a time
  a_r6_irq_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqKbd, irqMouse}));
  // R4: one write yields at most one outgoing strobe
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({replyValid, devWrValid, cmdErr, sysResetReq}));
  // R10: a data write clears the command flag
  a_r10_data_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dataWrite |=> !busRdata[3] || !busAddr);
  // R7: translation follows a fresh mode load
  a_r7_trans_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctl.ldMode |=> transEn == $past(busWdata[MODE_TRANS_BIT]));
endmodule

// File: rtl/kbcSequencer.sv
module kbcSequencer
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_RST = 8'h03,
  parameter logic [7:0] OUTP_RST = 8'hCF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic       busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       bufFull,
  input  logic       bufAux,
  input  logic [7:0] bufData,
  output logic       replyValid,
  output logic       replyAux,
  output logic [7:0] replyByte,
  output logic       devWrValid,
  output logic       devWrMouse,
  output logic [7:0] devWrByte,
  output logic [7:0] outPort,
  output logic       transEn,
  output logic       irqKbd,
  output logic       irqMouse,
  output logic       sysResetReq,
  output logic       cmdErr
);
  ctl_t ctl;

  kbcCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .ctl(ctl)
  );

  kbcDatapath #(.MODE_RST(MODE_RST), .OUTP_RST(OUTP_RST)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busWdata(busWdata), .busAddr(busAddr),
    .bufFull(bufFull), .bufAux(bufAux), .bufData(bufData), .busRdata(busRdata),
    .replyValid(replyValid), .replyAux(replyAux), .replyByte(replyByte),
    .devWrValid(devWrValid), .devWrMouse(devWrMouse), .devWrByte(devWrByte),
    .outPort(outPort), .transEn(transEn), .irqKbd(irqKbd), .irqMouse(irqMouse),
    .sysResetReq(sysResetReq), .cmdErr(cmdErr)
  );
endmodule

// File: tb/sim_kbcSequencer.sv
`timescale 1ns/1ps
module sim_kbcSequencer;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       busWr = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic       bufFull = 1'b0, bufAux = 1'b0;
  logic [7:0] bufData = '0;
  logic       replyValid, replyAux, devWrValid, devWrMouse;
  logic [7:0] replyByte, devWrByte, outPort;
  logic       transEn, irqKbd, irqMouse, sysResetReq, cmdErr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  kbcSequencer u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // write one byte; returns at the falling edge after the accepting edge
  task automatic put(input logic a, input logic [7:0] b);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = b;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic readStatus(output logic [7:0] v);
    busAddr = 1'b1; #1 v = busRdata;
  endtask

  task automatic expReply(input string tag, input logic [7:0] b, input logic aux);
    chk({tag, " replyValid"}, replyValid, 1);
    chk({tag, " replyByte"}, replyByte, b);
    chk({tag, " replyAux"}, replyAux, aux);
  endtask

  task automatic readMode(input string tag, input logic [7:0] exp);
    put(1'b1, 8'h20);
    expReply(tag, exp, 1'b0);
  endtask

  task automatic tReset;
    logic [7:0] s;
    readStatus(s);
    chk("R1 status", s, 8'h18);
    chk("R1 outPort", outPort, 8'hCF);
    chk("R1 transEn", transEn, 0);
    chk("R1 strobes", {replyValid, devWrValid, sysResetReq, cmdErr}, 0);
    readMode("R1/R2 mode via 0x20", 8'h03);
  endtask

  task automatic tRead;
    logic [7:0] s;
    bufFull = 1'b1; bufAux = 1'b0; bufData = 8'h5A;
    readStatus(s); chk("R10 status kbd full", s, 8'h19);
    bufAux = 1'b1;
    readStatus(s); chk("R10 status mouse full", s, 8'h39);
    busAddr = 1'b0; #1 chk("R11 data read", busRdata, 8'h5A);
    bufFull = 1'b0; bufAux = 1'b0;
  endtask

  task automatic tReplies;
    logic [7:0] s;
    put(1'b1, 8'hAA); expReply("R5 0xAA", 8'h55, 1'b0);
    readStatus(s); chk("R5 selftest bit", s, 8'h1C);
    put(1'b1, 8'hA9); expReply("R5 0xA9", 8'h00, 1'b0);
    put(1'b1, 8'hAB); expReply("R5 0xAB", 8'h00, 1'b0);
    put(1'b1, 8'hC0); expReply("R5 0xC0", 8'h80, 1'b0);
  endtask

  task automatic tPending;
    logic [7:0] s;
    put(1'b1, 8'h60); put(1'b0, 8'h43);
    chk("R3 mode load quiet", {replyValid, devWrValid}, 0);
    chk("R7 transEn set", transEn, 1);
    readMode("R3 mode loaded", 8'h43);
    put(1'b1, 8'h60); put(1'b0, 8'h03);
    chk("R7 transEn clear", transEn, 0);
    put(1'b1, 8'hD1); put(1'b0, 8'hAB);
    chk("R3 outPort", outPort, 8'hAB);
    put(1'b1, 8'hD2); put(1'b0, 8'h11); expReply("R3 kbd obuf", 8'h11, 1'b0);
    put(1'b1, 8'hD3); put(1'b0, 8'h22); expReply("R3 mouse obuf", 8'h22, 1'b1);
    put(1'b1, 8'hD4); put(1'b0, 8'h33);
    chk("R3 mouse dev", {devWrValid, devWrMouse, devWrByte}, {2'b11, 8'h33});
    put(1'b0, 8'h44);
    chk("R3/R4 cleared -> kbd dev", {devWrValid, devWrMouse, devWrByte}, {2'b10, 8'h44});
    readStatus(s); chk("R10 data clears bit3", s, 8'h14);
    put(1'b1, 8'hA8);
    readStatus(s); chk("R10 cmd sets bit3", s, 8'h1C);
  endtask

  task automatic tDisable;
    bufFull = 1'b1; bufAux = 1'b0;
    #1 chk("R6 irqKbd on", irqKbd, 1);
    put(1'b1, 8'hAD); chk("R6 kbd disabled irq", irqKbd, 0);
    readMode("R6 mode bit4", 8'h13);
    put(1'b1, 8'hAE); chk("R6 kbd enabled irq", irqKbd, 1);
    put(1'b1, 8'hA7); readMode("R6 mode bit5 set", 8'h23);
    put(1'b1, 8'hA8); readMode("R6 mode bit5 clr", 8'h03);
    bufAux = 1'b1;
    #1 chk("R6 irq mouse", {irqMouse, irqKbd}, 2'b10);
    put(1'b1, 8'h60); put(1'b0, 8'h01);
    chk("R6 mouse int masked", irqMouse, 0);
    put(1'b1, 8'h60); put(1'b0, 8'h03);
    bufFull = 1'b0; bufAux = 1'b0;
  endtask

  task automatic tPulse;
    put(1'b1, 8'hF0); chk("R8 0xF0 reset", {sysResetReq, cmdErr}, 2'b10);
    put(1'b1, 8'hFE); chk("R8 0xFE reset", {sysResetReq, cmdErr}, 2'b10);
    put(1'b1, 8'hFF);
    chk("R8 0xFF no-op", {sysResetReq, cmdErr, replyValid, devWrValid}, 0);
    put(1'b1, 8'hF1); chk("R8 0xF1 no-op", {sysResetReq, cmdErr}, 0);
    readMode("R8 mode untouched", 8'h03);
  endtask

  task automatic tBad;
    logic [7:0] s;
    put(1'b1, 8'h60);
    put(1'b1, 8'h55); chk("R9 err strobe", {cmdErr, replyValid}, 2'b10);
    @(negedge clk); chk("R9 err one cycle", cmdErr, 0);
    put(1'b0, 8'h07); chk("R9 pending kept", devWrValid, 0);
    readMode("R9 mode via kept pending", 8'h07);
    put(1'b0, 8'h99);
    put(1'b1, 8'h00); chk("R9 err 0x00", cmdErr, 1);
    readStatus(s); chk("R9 status bit3 kept", s, 8'h14);
    chk("R9 outPort kept", outPort, 8'hAB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tRead();
    tReplies();
    tPending();
    tDisable();
    tPulse();
    tBad();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule